// File: doc/BRIEF.md
# Smartcard ATR parser and session tracker

This block sits beside a receive-only UART that listens to the I/O line of an ISO 7816-3 card interface. It sees every received character as a one-cycle strobe with a data byte, along with the card reset line and a timeout pulse from a companion waiting-time timer. From these inputs it keeps track of where the session stands. The five phases are card held in reset, waiting for the first character of the Answer-To-Reset, inside the Answer-To-Reset, idle between commands, and inside a command exchange.

While the Answer-To-Reset is arriving, the block walks the chain of interface characters. The high nibble of the format character and of every chaining character announces which optional characters follow. Along the way the block captures the historical-byte count, the clock-rate and baud-rate indices from the first group, and the waiting-time integer. Once the closing check character has been consumed, it loads a new clock-rate divisor (F/D) and a new waiting time (960 x D x WI). Each of these values comes with a one-cycle update strobe, so the receiver's baud generator and the timer can reload. The check character is not verified. Bytes between commands are not decoded.

Top module: `atr_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to phase RESET (code 0), `rate_ratio`=372, `wait_time`=9600, `atr_fi`=1, `atr_di`=1, `atr_wi`=10, `atr_hist`=0, and both strobes are 0.
- R2: When `card_rst_n` is low at an edge, the phase becomes RESET from any phase. Received bytes and timeouts have no effect while the phase is RESET.
- R3: When the phase is RESET and `card_rst_n` is high at an edge, the phase becomes WAIT_ATR (code 1). In the same cycle `rate_ratio`=372 with `rate_upd`=1 and `wait_time`=9600 with `wait_upd`=1. Fi and Di indices return to 1, WI to 10 and the historical count to 0.
- R4: In WAIT_ATR, the first byte is taken as the initial character, whatever its value, and the phase becomes IN_ATR (code 2).
- R5: The next byte is the format character. Its low nibble is the historical count (`atr_hist`). Its bits 4, 5, 6 and 7 announce the optional characters A, B, C and D of a group, which are consumed in that order. Each D character announces the next group with its own bits 4 to 7. After the last group come `atr_hist` historical bytes, and then exactly one check character.
- R6: An A character of the first group (before any D character) loads `atr_fi` from its bits 7:4 and `atr_di` from its bits 3:0. A characters of later groups change neither.
- R7: A C character loads `atr_wi` when the most recent D character had low nibble 2. Any other C character leaves `atr_wi` unchanged.
- R8: When the check character is consumed, the phase becomes WAIT_APDU (code 3) in the next cycle. In that same cycle `wait_time` = 960 x D x WI, with `wait_upd`=1. D by Di index 0..9 is 0,1,2,4,8,16,32,64,12,20, and 0 for indices 10 to 15.
- R9: At that same point the ratio F/D (integer quotient) is loaded into `rate_ratio` with `rate_upd`=1, but only when it is greater than 0 and less than 1024. Otherwise `rate_ratio` keeps its value and `rate_upd` stays 0. F by Fi index 0..15 is 372,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0. D of 0 gives a ratio of 0.
- R10: In WAIT_APDU or IN_APDU, a byte moves the phase to IN_APDU (code 4) and a timeout moves it to WAIT_APDU. When both arrive in the same cycle, the timeout wins. A timeout in RESET, WAIT_ATR or IN_ATR has no effect.
- R11: `rate_upd` and `wait_upd` pulse only at the points named in R3, R8 and R9. `rate_ratio` and `wait_time` change only in a cycle whose strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| card_rst_n | input | 1 | Card reset line, low = card held in reset |
| rx_vld | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| wt_expired | input | 1 | One-cycle pulse: waiting time ran out |
| phase | output | 3 | Session phase code |
| rate_ratio | output | RATIO_W (10) | Clock cycles per elementary time unit |
| rate_upd | output | 1 | `rate_ratio` was just loaded |
| wait_time | output | WT_W (24) | Waiting time in elementary time units |
| wait_upd | output | 1 | `wait_time` was just loaded |
| atr_fi | output | 4 | Captured clock-rate index |
| atr_di | output | 4 | Captured baud-rate index |
| atr_wi | output | 8 | Current waiting-time integer |
| atr_hist | output | 4 | Historical byte count from the format character |

## Verification
The bench aims at the chain walk. It uses answers with a deep chain of D characters, with groups that carry only B/C/D characters, with zero historical bytes, and with a second-group A character that must not overwrite the first-group indices. A parser that skips a chain step would treat the check character as data, and the phase would never leave IN_ATR. The C rule is exercised with the governing D nibble both equal to 2 and not equal to 2, so a design that loads WI from every C character would report the wrong waiting time. The ratio limit is hit with a divisor of 2048, where a design without the range check would load a truncated rate. Divisors of 12 and 20 are also covered. Finally, a timeout that collides with a byte, timeouts inside the ATR, and a card reset in the middle of an ATR check the phase priorities.

// File: rtl/atr_trk_pkg.sv
// Shared types and lookup functions for the ATR tracker.
// Assumes the standard clock-rate and baud-rate index tables.
package atr_trk_pkg;

    typedef enum logic [2:0] {
        PH_RESET     = 3'd0,
        PH_WAIT_ATR  = 3'd1,
        PH_IN_ATR    = 3'd2,
        PH_WAIT_APDU = 3'd3,
        PH_IN_APDU   = 3'd4
    } phase_e;

    typedef enum logic [3:0] {
        SB_TS, SB_T0, SB_TA, SB_TB, SB_TC, SB_TD, SB_HIST, SB_TCK, SB_DONE
    } sub_e;

    // Clock-rate conversion factor F by index (0 = reserved)
    function automatic logic [11:0] rate_f(input logic [3:0] idx);
        logic [11:0] f;
        case (idx)
            4'd0, 4'd1: f = 12'd372;
            4'd2:       f = 12'd558;
            4'd3:       f = 12'd744;
            4'd4:       f = 12'd1116;
            4'd5:       f = 12'd1488;
            4'd6:       f = 12'd1860;
            4'd9:       f = 12'd512;
            4'd10:      f = 12'd768;
            4'd11:      f = 12'd1024;
            4'd12:      f = 12'd1536;
            4'd13:      f = 12'd2048;
            default:    f = 12'd0;
        endcase
        return f;
    endfunction

    // Baud-rate adjustment factor D by index (0 = reserved)
    function automatic logic [6:0] adj_d(input logic [3:0] idx);
        logic [6:0] d;
        case (idx)
            4'd1:    d = 7'd1;
            4'd2:    d = 7'd2;
            4'd3:    d = 7'd4;
            4'd4:    d = 7'd8;
            4'd5:    d = 7'd16;
            4'd6:    d = 7'd32;
            4'd7:    d = 7'd64;
            4'd8:    d = 7'd12;
            4'd9:    d = 7'd20;
            default: d = 7'd0;
        endcase
        return d;
    endfunction

    // Integer quotient F/D; powers of two by shift, 12 and 20 by constant divide
    function automatic logic [11:0] fd_quot(input logic [3:0] fi, input logic [3:0] di);
        logic [11:0] f;
        logic [11:0] q;
        f = rate_f(fi);
        case (di)
            4'd1:    q = f;
            4'd2:    q = f >> 1;
            4'd3:    q = f >> 2;
            4'd4:    q = f >> 3;
            4'd5:    q = f >> 4;
            4'd6:    q = f >> 5;
            4'd7:    q = f >> 6;
            4'd8:    q = f / 12'd12;
            4'd9:    q = f / 12'd20;
            default: q = 12'd0;
        endcase
        return q;
    endfunction

    // First announced character at or after position 'from' (0=A..3=D),
    // otherwise historical bytes if any remain, otherwise the check byte
    function automatic sub_e chain_next(input logic [3:0] y, input logic [2:0] from,
                                        input logic hist_pend);
        sub_e r;
        logic hit;
        r   = hist_pend ? SB_HIST : SB_TCK;
        hit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!hit && (3'(i) >= from) && y[i]) begin
                hit = 1'b1;
                case (i)
                    0:       r = SB_TA;
                    1:       r = SB_TB;
                    2:       r = SB_TC;
                    default: r = SB_TD;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/atr_chain_parser.sv
// Walks the Answer-To-Reset character chain one byte at a time.
// Captures the historical count, first-group Fi/Di and WI.
// Assumes 'start' and 'byte_en' are never high together.
module atr_chain_parser
    import atr_trk_pkg::*;
#(
    parameter int unsigned INIT_WI = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       byte_en,
    input  logic [7:0] byte_dat,
    output logic       tck_hit,
    output logic [3:0] fi_q,
    output logic [3:0] di_q,
    output logic [7:0] wi_q,
    output logic [3:0] hist_q
);
    sub_e       sub_q;
    logic [3:0] y_q;        // presence nibble of the current group
    logic [3:0] last_lo_q;  // low nibble of the latest chaining character
    logic       grp1_q;     // still inside the first group
    logic [3:0] left_q;     // historical bytes still to come
    logic       pend;

    assign pend    = (left_q != 4'd0);
    assign tck_hit = byte_en && (sub_q == SB_TCK);

    // Chain walk and field capture
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            sub_q     <= SB_TS;
            y_q       <= 4'd0;
            last_lo_q <= 4'd0;
            grp1_q    <= 1'b1;
            left_q    <= 4'd0;
            hist_q    <= 4'd0;
            fi_q      <= 4'd1;
            di_q      <= 4'd1;
            wi_q      <= 8'(INIT_WI);
        end else if (byte_en) begin
            case (sub_q)
                SB_TS: sub_q <= SB_T0;
                SB_T0: begin
                    hist_q    <= byte_dat[3:0];
                    left_q    <= byte_dat[3:0];
                    y_q       <= byte_dat[7:4];
                    last_lo_q <= 4'd0;
                    grp1_q    <= 1'b1;
                    sub_q     <= chain_next(byte_dat[7:4], 3'd0, byte_dat[3:0] != 4'd0);
                end
                SB_TA: begin
                    if (grp1_q) begin
                        fi_q <= byte_dat[7:4];
                        di_q <= byte_dat[3:0];
                    end
                    sub_q <= chain_next(y_q, 3'd1, pend);
                end
                SB_TB: sub_q <= chain_next(y_q, 3'd2, pend);
                SB_TC: begin
                    if (last_lo_q == 4'd2) wi_q <= byte_dat;
                    sub_q <= chain_next(y_q, 3'd3, pend);
                end
                SB_TD: begin
                    y_q       <= byte_dat[7:4];
                    last_lo_q <= byte_dat[3:0];
                    grp1_q    <= 1'b0;
                    sub_q     <= chain_next(byte_dat[7:4], 3'd0, pend);
                end
                SB_HIST: begin
                    left_q <= left_q - 4'd1;
                    sub_q  <= (left_q == 4'd1) ? SB_TCK : SB_HIST;
                end
                SB_TCK:  sub_q <= SB_DONE;
                default: sub_q <= sub_q;
            endcase
        end
    end

    // Historical state is only entered while bytes remain
    p_hist_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && (sub_q == SB_HIST) |-> (left_q != 4'd0));

    // Later-group A characters leave the indices alone
    p_ta_later_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && (sub_q == SB_TA) && !grp1_q |=> $stable(fi_q) && $stable(di_q));

    // WI only follows a chaining nibble of 2
    p_wi_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && (sub_q == SB_TC) && (last_lo_q != 4'd2) |=> $stable(wi_q));

endmodule

// File: rtl/atr_rate_calc.sv
// Derives the F/D divisor and the post-ATR waiting time from the captured
// indices. Purely combinational; the caller decides when to load.
module atr_rate_calc
    import atr_trk_pkg::*;
#(
    parameter int unsigned RATIO_LIMIT = 1024,
    parameter int unsigned WT_W        = 24,
    parameter int unsigned WT_UNIT     = 960,
    localparam int unsigned RATIO_W    = $clog2(RATIO_LIMIT)
) (
    input  logic [3:0]         fi,
    input  logic [3:0]         di,
    input  logic [7:0]         wi,
    output logic [RATIO_W-1:0] ratio_val,
    output logic               ratio_ok,
    output logic [WT_W-1:0]    wt_val
);
    logic [11:0] quot;

    // Divisor and its acceptance window
    always_comb begin
        quot      = fd_quot(fi, di);
        ratio_ok  = (quot != 12'd0) && (32'(quot) < RATIO_LIMIT);
        ratio_val = RATIO_W'(quot);
    end

    // Waiting time in elementary time units
    always_comb begin
        wt_val = WT_W'(WT_UNIT) * WT_W'(adj_d(di)) * WT_W'(wi);
    end

endmodule

// File: rtl/atr_tracker.sv
// Session phase tracker for a passively observed ISO 7816-3 link.
// Owns the phase machine and the rate/waiting-time output registers.
// Assumes rx_vld and wt_expired are single-cycle strobes.
module atr_tracker
    import atr_trk_pkg::*;
#(
    parameter int unsigned RATIO_LIMIT = 1024,
    parameter int unsigned WT_W        = 24,
    parameter int unsigned WT_UNIT     = 960,
    parameter int unsigned INIT_WT     = 9600,
    parameter int unsigned INIT_WI     = 10,
    localparam int unsigned RATIO_W    = $clog2(RATIO_LIMIT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_rst_n,
    input  logic               rx_vld,
    input  logic [7:0]         rx_byte,
    input  logic               wt_expired,
    output logic [2:0]         phase,
    output logic [RATIO_W-1:0] rate_ratio,
    output logic               rate_upd,
    output logic [WT_W-1:0]    wait_time,
    output logic               wait_upd,
    output logic [3:0]         atr_fi,
    output logic [3:0]         atr_di,
    output logic [7:0]         atr_wi,
    output logic [3:0]         atr_hist
);
    localparam logic [11:0] INIT_Q = fd_quot(4'd1, 4'd1);

    phase_e             phase_q;
    logic               start;
    logic               byte_en;
    logic               tck_hit;
    logic [RATIO_W-1:0] calc_ratio;
    logic               calc_ok;
    logic [WT_W-1:0]    calc_wt;

    assign phase   = phase_q;
    assign start   = card_rst_n && (phase_q == PH_RESET);
    assign byte_en = rx_vld && card_rst_n &&
                     ((phase_q == PH_WAIT_ATR) || (phase_q == PH_IN_ATR));

    atr_chain_parser #(.INIT_WI(INIT_WI)) u_parse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .byte_en  (byte_en),
        .byte_dat (rx_byte),
        .tck_hit  (tck_hit),
        .fi_q     (atr_fi),
        .di_q     (atr_di),
        .wi_q     (atr_wi),
        .hist_q   (atr_hist)
    );

    atr_rate_calc #(
        .RATIO_LIMIT (RATIO_LIMIT),
        .WT_W        (WT_W),
        .WT_UNIT     (WT_UNIT)
    ) u_calc (
        .fi        (atr_fi),
        .di        (atr_di),
        .wi        (atr_wi),
        .ratio_val (calc_ratio),
        .ratio_ok  (calc_ok),
        .wt_val    (calc_wt)
    );

    // Phase machine and output value registers
    always_ff @(posedge clk) begin
        rate_upd <= 1'b0;
        wait_upd <= 1'b0;
        if (!rst_n) begin
            phase_q    <= PH_RESET;
            rate_ratio <= RATIO_W'(INIT_Q);
            wait_time  <= WT_W'(INIT_WT);
        end else if (!card_rst_n) begin
            phase_q <= PH_RESET;
        end else begin
            case (phase_q)
                PH_RESET: begin
                    phase_q    <= PH_WAIT_ATR;
                    rate_ratio <= RATIO_W'(INIT_Q);
                    rate_upd   <= 1'b1;
                    wait_time  <= WT_W'(INIT_WT);
                    wait_upd   <= 1'b1;
                end
                PH_WAIT_ATR: if (rx_vld) phase_q <= PH_IN_ATR;
                PH_IN_ATR: begin
                    if (tck_hit) begin
                        phase_q   <= PH_WAIT_APDU;
                        wait_time <= calc_wt;
                        wait_upd  <= 1'b1;
                        if (calc_ok) begin
                            rate_ratio <= calc_ratio;
                            rate_upd   <= 1'b1;
                        end
                    end
                end
                PH_WAIT_APDU, PH_IN_APDU: begin
                    if (wt_expired)  phase_q <= PH_WAIT_APDU;
                    else if (rx_vld) phase_q <= PH_IN_APDU;
                end
                default: phase_q <= PH_RESET;
            endcase
        end
    end

    p_card_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !card_rst_n |=> (phase_q == PH_RESET) && !rate_upd && !wait_upd);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESET) && card_rst_n |=>
            (phase_q == PH_WAIT_ATR) && rate_upd && wait_upd && (wait_time == WT_W'(INIT_WT)));

    p_tck_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IN_ATR) && tck_hit && card_rst_n |=> (phase_q == PH_WAIT_APDU) && wait_upd);

    p_ratio_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_upd |-> (rate_ratio != '0));

    p_apdu_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_WAIT_APDU) || (phase_q == PH_IN_APDU)) && rx_vld && !wt_expired && card_rst_n
            |=> (phase_q == PH_IN_APDU));

    p_apdu_tmo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_WAIT_APDU) || (phase_q == PH_IN_APDU)) && wt_expired && card_rst_n
            |=> (phase_q == PH_WAIT_APDU));

    p_ratio_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_upd |-> $stable(rate_ratio));

    p_wt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_upd |-> $stable(wait_time));

endmodule

// File: tb/tb_atr_tracker.sv
module tb_atr_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_rst_n = 1'b0;
    logic        rx_vld = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        wt_expired = 1'b0;
    logic [2:0]  phase;
    logic [9:0]  rate_ratio;
    logic        rate_upd;
    logic [23:0] wait_time;
    logic        wait_upd;
    logic [3:0]  atr_fi, atr_di, atr_hist;
    logic [7:0]  atr_wi;

    always #10 clk = ~clk;

    atr_tracker dut (
        .clk(clk), .rst_n(rst_n), .card_rst_n(card_rst_n), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .wt_expired(wt_expired), .phase(phase),
        .rate_ratio(rate_ratio), .rate_upd(rate_upd), .wait_time(wait_time),
        .wait_upd(wait_upd), .atr_fi(atr_fi), .atr_di(atr_di), .atr_wi(atr_wi),
        .atr_hist(atr_hist)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit started = 0;

    // Reference model state
    localparam int K_TA = 0, K_TB = 1, K_TC = 2, K_TD = 3, K_T0 = 4, K_HIST = 5, K_TCK = 6;
    int ftab [16] = '{372,372,558,744,1116,1488,1860,0,0,512,768,1024,1536,2048,0,0};
    int dtab [16] = '{0,1,2,4,8,16,32,64,12,20,0,0,0,0,0,0};
    int pend [$];
    int m_phase = 0, m_ratio = 372, m_wt = 9600, m_fi = 1, m_di = 1, m_wi = 10, m_hist = 0;
    int m_left = 0, m_lastlo = 0;
    bit m_g1 = 1, m_rupd = 0, m_wupd = 0;

    function automatic void push_kinds(int y);
        for (int i = 0; i < 4; i++) if (y[i]) pend.push_back(i);
    endfunction

    function automatic void model_atr(int b);
        int k, q;
        if (pend.size() > 0) k = pend.pop_front();
        else k = (m_left > 0) ? K_HIST : K_TCK;
        case (k)
            K_T0: begin
                m_hist = b & 15; m_left = m_hist; m_g1 = 1; m_lastlo = 0;
                push_kinds(b >> 4);
            end
            K_TA: if (m_g1) begin m_fi = b >> 4; m_di = b & 15; end
            K_TC: if (m_lastlo == 2) m_wi = b;
            K_TD: begin m_g1 = 0; m_lastlo = b & 15; push_kinds(b >> 4); end
            K_HIST: m_left--;
            K_TCK: begin
                m_phase = 3;
                m_wt = 960 * dtab[m_di] * m_wi; m_wupd = 1;
                q = (dtab[m_di] == 0) ? 0 : ftab[m_fi] / dtab[m_di];
                if (q > 0 && q < 1024) begin m_ratio = q; m_rupd = 1; end
            end
            default: ;
        endcase
    endfunction

    always @(posedge clk) begin
        m_rupd = 0; m_wupd = 0;
        if (!rst_n) begin
            m_phase = 0; m_ratio = 372; m_wt = 9600; m_fi = 1; m_di = 1; m_wi = 10; m_hist = 0;
        end else if (!card_rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: begin
                    m_phase = 1; m_fi = 1; m_di = 1; m_wi = 10; m_hist = 0; m_left = 0;
                    m_ratio = 372; m_rupd = 1; m_wt = 9600; m_wupd = 1; pend.delete();
                end
                1: if (rx_vld) begin m_phase = 2; pend.delete(); pend.push_back(K_T0); end
                2: if (rx_vld) model_atr(int'(rx_byte));
                3, 4: if (wt_expired) m_phase = 3; else if (rx_vld) m_phase = 4;
                default: ;
            endcase
        end
        started = 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk(tag, "phase", int'(phase), m_phase);
            chk(tag, "rate_ratio", int'(rate_ratio), m_ratio);
            chk(tag, "rate_upd", int'(rate_upd), int'(m_rupd));
            chk(tag, "wait_time", int'(wait_time), m_wt);
            chk(tag, "wait_upd", int'(wait_upd), int'(m_wupd));
            chk(tag, "atr_fi", int'(atr_fi), m_fi);
            chk(tag, "atr_di", int'(atr_di), m_di);
            chk(tag, "atr_wi", int'(atr_wi), m_wi);
            chk(tag, "atr_hist", int'(atr_hist), m_hist);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_vld = 1'b1; rx_byte = b;
        @(negedge clk); rx_vld = 1'b0;
    endtask

    task automatic tmo();
        @(negedge clk); wt_expired = 1'b1;
        @(negedge clk); wt_expired = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic card_reset();
        @(negedge clk); card_rst_n = 1'b0;
        idle(2);
        card_rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        chk("R1", "phase", int'(phase), 0);
        chk("R1", "rate_ratio", int'(rate_ratio), 372);
        chk("R1", "wait_time", int'(wait_time), 9600);
        rst_n = 1'b1;
        // R2: bytes and timeouts while card held in reset are ignored
        tag = "R2";
        send(8'h3B); tmo();
        chk("R2", "phase", int'(phase), 0);
        // R3: release
        tag = "R3";
        @(negedge clk); card_rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "phase", int'(phase), 1);
        chk("R3", "rate_upd", int'(rate_upd), 1);
        chk("R3", "wait_upd", int'(wait_upd), 1);
        // R4: initial character of any value
        tag = "R4";
        send(8'h3F);
        chk("R4", "phase", int'(phase), 2);
        // R5 R6 R7: A and D in group 1, C after nibble 2, five historical bytes
        tag = "R5";
        send(8'h95); chk("R5", "atr_hist", int'(atr_hist), 5);
        tag = "R6";
        send(8'h96); chk("R6", "atr_fi", int'(atr_fi), 9);
        tmo();   // R10: timeout inside ATR ignored
        chk("R10", "phase", int'(phase), 2);
        tag = "R7";
        send(8'h42); send(8'h20); chk("R7", "atr_wi", int'(atr_wi), 32);
        tag = "R5";
        for (int i = 0; i < 5; i++) send(8'(8'h11 * (i + 1)));
        chk("R5", "phase before check byte", int'(phase), 2);
        tag = "R8";
        send(8'h00);
        chk("R8", "phase", int'(phase), 3);
        chk("R8", "wait_time", int'(wait_time), 983040);
        chk("R8", "wait_upd", int'(wait_upd), 1);
        chk("R9", "rate_ratio", int'(rate_ratio), 16);
        chk("R9", "rate_upd", int'(rate_upd), 1);
        // R10: command traffic and timeout priority
        tag = "R10";
        send(8'hA0); chk("R10", "phase", int'(phase), 4);
        send(8'hA4); tmo(); chk("R10", "phase", int'(phase), 3);
        send(8'h00);
        @(negedge clk); rx_vld = 1'b1; wt_expired = 1'b1;
        @(negedge clk); rx_vld = 1'b0; wt_expired = 1'b0;
        chk("R10", "phase both", int'(phase), 3);
        idle(3);
        chk("R11", "rate_upd idle", int'(rate_upd), 0);
        // R2: card reset mid command returns to RESET, then R3 reinit
        tag = "R2";
        @(negedge clk); card_rst_n = 1'b0;
        @(negedge clk); chk("R2", "phase", int'(phase), 0);
        card_rst_n = 1'b1;
        @(negedge clk);
        tag = "R3";
        chk("R3", "rate_ratio", int'(rate_ratio), 372);
        chk("R3", "atr_wi", int'(atr_wi), 10);
        // ATR with B,C,D in group 1, second-group A ignored, no historical bytes
        tag = "R6";
        send(8'h3B); send(8'hE0); send(8'h00); send(8'hFF);
        chk("R7", "atr_wi unchanged", int'(atr_wi), 10);
        send(8'h11); send(8'h13);
        chk("R6", "atr_fi", int'(atr_fi), 1);
        chk("R6", "atr_di", int'(atr_di), 1);
        tag = "R8";
        send(8'h5A);
        chk("R8", "phase", int'(phase), 3);
        chk("R9", "rate_ratio", int'(rate_ratio), 372);
        chk("R8", "wait_time", int'(wait_time), 9600);
        // ATR whose ratio is out of range
        card_reset();
        tag = "R9";
        send(8'h3B); send(8'h10); send(8'hD1); send(8'h00);
        chk("R9", "rate_upd rejected", int'(rate_upd), 0);
        chk("R9", "rate_ratio kept", int'(rate_ratio), 372);
        chk("R8", "wait_upd", int'(wait_upd), 1);
        // Card reset in the middle of an ATR
        card_reset();
        tag = "R2";
        send(8'h3B); send(8'h11);
        @(negedge clk); card_rst_n = 1'b0;
        @(negedge clk); chk("R2", "phase", int'(phase), 0);
        card_rst_n = 1'b1;
        @(negedge clk);
        // Divisor 12
        tag = "R9";
        send(8'h3B); send(8'h11); send(8'h58); send(8'hAA); send(8'h00);
        chk("R9", "rate_ratio", int'(rate_ratio), 124);
        chk("R8", "wait_time", int'(wait_time), 115200);
        // Divisor 20
        card_reset();
        send(8'h3B); send(8'h10); send(8'h99); send(8'h00);
        chk("R9", "rate_ratio", int'(rate_ratio), 25);
        chk("R8", "wait_time", int'(wait_time), 192000);
        // Two chaining characters, C after nibble 2 in the third group
        card_reset();
        tag = "R5";
        send(8'h3B); send(8'h81); send(8'h81); send(8'h42);
        tag = "R7";
        send(8'h05); chk("R7", "atr_wi", int'(atr_wi), 5);
        tag = "R5";
        send(8'h77);
        chk("R5", "phase before check byte", int'(phase), 2);
        send(8'h00);
        chk("R8", "wait_time", int'(wait_time), 4800);
        chk("R5", "phase", int'(phase), 3);
        tag = "R11";
        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule